// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block derives a one-microsecond tick enable from a fast reference clock. The reference frequency does not have to be a whole number of megahertz. A 16-bit ratio setting holds two fields. One field is a tick count and the other is a reference-cycle count, and each field is stored as its value minus one. The generator emits exactly the programmed number of ticks within every window of the programmed number of reference cycles. A phase accumulator spreads those ticks as evenly as it can. Settings such as 0x043F (5 ticks in 64 cycles, a 12.8 MHz reference) or 0x045F (5 ticks in 96 cycles, a 19.2 MHz reference) therefore give a correct long-term microsecond rate.

Each tick advances a free-running 32-bit microsecond counter. Software reads the counter over a simple register port, with a single-cycle write strobe and combinational read data. A hold register stops the counter while the tick generator keeps running in phase. Software chooses the ratio for its reference clock and writes it. Every write to the ratio register restarts the accumulator from zero.

The counter is governed by a two-state machine. In `CNT_LIVE` the counter adds one on each tick. In `CNT_HELD` the counter keeps its value. The transition LIVE→HELD fires on a write of 1 in bit 0 of the hold register. The transition HELD→LIVE fires on a write of 0 in that bit. Any other cycle keeps the current state.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset the ratio register reads 0x0000000B, the counter reads 0, the hold register reads 0, and `us_tick` is low.
- R2: The ratio register at offset 0x14 stores write-data bits [15:0]. Bits [7:0] hold the reference-cycle count minus one (D-1), and bits [15:8] hold the tick count minus one (N-1). Bits above 15 read back as zero.
- R3: After a ratio write, `us_tick` is high in exactly floor(k·min(N,D)/D) of the first k cycles that follow the write edge, and each high is a single-cycle pulse decided by the accumulator.
- R4: The counter at offset 0x10 increments by exactly one on the clock edge that follows each cycle in which `us_tick` is high. At no other time does it change, so k edges after a ratio write it has advanced by floor((k-1)·min(N,D)/D).
- R5: A write to the ratio register clears the accumulator and forces `us_tick` low in the cycle that follows the write edge, even if a tick was due.
- R6: Writing 1 to bit 0 of the hold register at offset 0x4C enters `CNT_HELD`. There the counter keeps its value. Writing 0 to that bit returns to `CNT_LIVE`. The register reads back the current state in bit 0.
- R7: While the counter is held, the tick generator keeps its phase, so the tick count over a window that spans a hold and a release still matches R3.
- R8: When N ≥ D, `us_tick` is high in every cycle except the one after a ratio write.
- R9: Writes to the counter offset or to any unmapped offset change no state, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| us_tick | output | 1 | One-cycle microsecond tick enable |

## Verification
The hardest case to reach from the ports is a hold window whose edges line up with tick decisions. A tick decided on the last held cycle must be dropped, and the tick rhythm must run on unbroken across the release. The stimulus restarts the accumulator with a ratio write just before the hold. That restart makes the tick decisions fall on known cycles, so the hold and the release are placed with exact cycle counts: one tick lands on the final held edge and is lost to the counter, yet it is still counted on `us_tick`. A second case writes the ratio while a tick is pending in the saturated N ≥ D mode, to show that the restart suppresses it.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;

    // Register byte offsets decoded by software
    localparam logic [7:0] OFS_COUNT  = 8'h10;
    localparam logic [7:0] OFS_RATIO  = 8'h14;
    localparam logic [7:0] OFS_FREEZE = 8'h4C;

    typedef enum logic {
        CNT_LIVE = 1'b0,
        CNT_HELD = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/usec_ratio_accum.sv
module usec_ratio_accum #(
    parameter int FIELD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*FIELD_W-1:0] ratio_cfg,
    input  logic                 ratio_load,
    output logic                 tick
);
    localparam int AW = FIELD_W + 1;
    localparam int SW = FIELD_W + 2;

    logic [AW-1:0] num;
    logic [AW-1:0] den;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_nx;
    logic [SW-1:0] sum;
    logic          fire;

    always_comb begin
        num    = AW'(ratio_cfg[2*FIELD_W-1:FIELD_W]) + AW'(1);
        den    = AW'(ratio_cfg[FIELD_W-1:0]) + AW'(1);
        sum    = SW'(acc_q) + SW'(num);
        fire   = 1'b0;
        acc_nx = sum[AW-1:0];
        if (num >= den) begin
            fire   = 1'b1;
            acc_nx = '0;
        end else if (sum >= SW'(den)) begin
            fire   = 1'b1;
            acc_nx = AW'(sum - SW'(den));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (ratio_load) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            acc_q <= acc_nx;
            tick  <= fire;
        end
    end

    // R3: the phase residue always stays below the cycle count
    a_r3_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < den);

    // R5: a ratio write restarts the phase and drops any pending tick
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_load |=> (acc_q == '0 && !tick));

    // R8: saturated ratio ticks on every cycle
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (num >= den && !ratio_load) |=> tick);

endmodule

// File: rtl/usec_count_ctrl.sv
module usec_count_ctrl
    import usec_tick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             freeze_wr,
    input  logic             freeze_val,
    output logic [CNT_W-1:0] count,
    output logic             held
);
    cnt_state_e state_q;
    cnt_state_e state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CNT_LIVE: if (freeze_wr && freeze_val)  state_nx = CNT_HELD;
            CNT_HELD: if (freeze_wr && !freeze_val) state_nx = CNT_LIVE;
            default:  state_nx = CNT_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_LIVE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (state_q)
                CNT_LIVE: if (tick) count <= count + CNT_W'(1);
                CNT_HELD: count <= count;
                default:  count <= count;
            endcase
        end
    end

    assign held = (state_q == CNT_HELD);

    // R4: a live tick advances the counter by exactly one
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_LIVE && tick) |=> count == $past(count) + CNT_W'(1));

    // R4: no tick, no movement
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    // R6: held state keeps the counter value
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HELD) |=> $stable(count));

endmodule

// File: rtl/usec_reg_file.sv
module usec_reg_file
    import usec_tick_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          FIELD_W     = 8,
    parameter int          CNT_W       = 32,
    parameter logic [15:0] RESET_RATIO = 16'h000B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [CNT_W-1:0]     count,
    input  logic                 held,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [2*FIELD_W-1:0] ratio_cfg,
    output logic                 ratio_load,
    output logic                 freeze_wr,
    output logic                 freeze_val
);
    localparam int RW = 2 * FIELD_W;

    logic hit_count;
    logic hit_ratio;
    logic hit_freeze;

    assign hit_count  = (bus_addr == ADDR_W'(OFS_COUNT));
    assign hit_ratio  = (bus_addr == ADDR_W'(OFS_RATIO));
    assign hit_freeze = (bus_addr == ADDR_W'(OFS_FREEZE));

    assign ratio_load = bus_wr && hit_ratio;
    assign freeze_wr  = bus_wr && hit_freeze;
    assign freeze_val = bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ratio_cfg <= RW'(RESET_RATIO);
        else if (ratio_load) ratio_cfg <= bus_wdata[RW-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_count)       bus_rdata = DATA_W'(count);
        else if (hit_ratio)  bus_rdata = DATA_W'(ratio_cfg);
        else if (hit_freeze) bus_rdata = DATA_W'(held);
    end

    // R2: the ratio register changes only on a write to its offset
    a_r2_ratio_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_load |=> $stable(ratio_cfg));

endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          FIELD_W     = 8,
    parameter int          CNT_W       = 32,
    parameter logic [15:0] RESET_RATIO = 16'h000B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              us_tick
);
    localparam int RW = 2 * FIELD_W;

    logic [RW-1:0]    ratio_cfg;
    logic             ratio_load;
    logic             freeze_wr;
    logic             freeze_val;
    logic [CNT_W-1:0] count;
    logic             held;

    usec_reg_file #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W),
        .CNT_W(CNT_W), .RESET_RATIO(RESET_RATIO)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count(count), .held(held),
        .bus_rdata(bus_rdata), .ratio_cfg(ratio_cfg), .ratio_load(ratio_load),
        .freeze_wr(freeze_wr), .freeze_val(freeze_val)
    );

    usec_ratio_accum #(.FIELD_W(FIELD_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .ratio_cfg(ratio_cfg),
        .ratio_load(ratio_load), .tick(us_tick)
    );

    usec_count_ctrl #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .freeze_wr(freeze_wr),
        .freeze_val(freeze_val), .count(count), .held(held)
    );

endmodule

// File: tb/usec_tick_gen_test.sv
`timescale 1ns/1ps
module usec_tick_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        us_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usec_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .us_tick(us_tick)
    );

    localparam int NV = 8;
    localparam int VEC_CFG [NV] = '{32'h000B, 32'h043F, 32'h045F, 32'h04BF,
                                    32'h0000, 32'h0201, 32'h0406, 32'h00FF};
    localparam int VEC_LEN [NV] = '{120, 128, 96, 192, 20, 10, 30, 300};

    function automatic int exp_ticks(int cfg, int k);
        int n = ((cfg >> 8) & 255) + 1;
        int d = (cfg & 255) + 1;
        int m = (n < d) ? n : d;
        return (k * m) / d;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic write_reg(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_reg(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(int n, inout int ticks);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            ticks += int'(us_tick);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base;
        int ticks;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_reg(8'h14, v); check("R1 ratio reset", v, 32'h0000000B);
        read_reg(8'h10, v); check("R1 counter reset", v, 32'h0);
        read_reg(8'h4C, v); check("R1 hold reset", v, 32'h0);
        check("R1 tick low", {31'b0, us_tick}, 32'h0);

        // R2: field storage and upper bits
        write_reg(8'h14, 32'hABCD_1234);
        read_reg(8'h14, v); check("R2 ratio readback", v, 32'h0000_1234);

        // R3, R4, R8: vector walk
        for (int i = 0; i < NV; i++) begin
            write_reg(8'h14, VEC_CFG[i]);
            read_reg(8'h10, base);
            ticks = 0;
            step(VEC_LEN[i], ticks);
            check($sformatf("R3 ticks cfg=%04h", VEC_CFG[i]), ticks,
                  exp_ticks(VEC_CFG[i], VEC_LEN[i]));
            read_reg(8'h10, v);
            check($sformatf("R4 count delta cfg=%04h", VEC_CFG[i]), v - base,
                  exp_ticks(VEC_CFG[i], VEC_LEN[i] - 1));
        end

        // R5: restart suppresses a pending tick in saturated mode (R8)
        write_reg(8'h14, 32'h0000);
        step(3, ticks);
        check("R8 saturated tick high", {31'b0, us_tick}, 32'h1);
        write_reg(8'h14, 32'h0000);
        check("R5 tick dropped after restart", {31'b0, us_tick}, 32'h0);
        step(1, ticks);
        check("R5 tick resumes", {31'b0, us_tick}, 32'h1);

        // R6, R7: hold across tick decisions
        write_reg(8'h14, 32'h000B);
        write_reg(8'h4C, 32'h1);
        ticks = int'(us_tick);
        read_reg(8'h10, base);
        read_reg(8'h4C, v); check("R6 hold readback", v, 32'h1);
        step(59, ticks);
        read_reg(8'h10, v); check("R6 counter held", v, base);
        write_reg(8'h4C, 32'h0);
        ticks += int'(us_tick);
        read_reg(8'h4C, v); check("R6 release readback", v, 32'h0);
        step(59, ticks);
        read_reg(8'h10, v); check("R6 count after release", v, base + 32'd4);
        check("R7 phase kept across hold", ticks, 10);

        // R9: writes to counter and unmapped offsets
        write_reg(8'h14, 32'h0000);
        step(2, ticks);
        read_reg(8'h10, base);
        write_reg(8'h10, 32'h0);
        read_reg(8'h10, v); check("R9 counter write ignored", v, base + 32'd1);
        write_reg(8'h20, 32'hFFFF_FFFF);
        read_reg(8'h20, v); check("R9 unmapped reads zero", v, 32'h0);
        read_reg(8'h14, v); check("R9 ratio untouched", v, 32'h0);
        read_reg(8'h4C, v); check("R9 hold untouched", v, 32'h0);
        check("R9 tick still running", {31'b0, us_tick}, 32'h1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule